// File: doc/BRIEF.md
# Thirty-Two Pin I/O Port Controller with Edge Interrupts

The block is a word-wide memory-mapped controller for 32 general-purpose pins. Software picks, per pin, whether the pin drives or listens, and whether a driving pin is push-pull or open-drain. A data register holds the output latch. When read, it returns the latch for driving pins and the synchronized pad level for listening pins. Every pad level passes through a two-flop synchronizer. A third flop then holds the previous sample so that edges can be detected.

Each pin can raise a sticky event. A per-pin sense bit chooses between falling edges only and any edge. Events are cleared by writing ones. A per-pin enable mask gates the events onto one combined interrupt request line.

Bus accesses are handled by a small two-state machine. In state `BS_IDLE`, a request is accepted (transition IDLE→RESP, the "accept" transition), any write takes effect and read data is captured. In state `BS_RESP`, the acknowledge is high for one cycle with the read data valid. The machine then returns unconditionally to `BS_IDLE` (transition RESP→IDLE, the "release" transition). While in `BS_RESP`, requests are not looked at.

Top module: `pio32_ctrl`

## Requirements
- R1: After reset, the direction, open-drain, data, event, mask and sense registers all read zero. `pad_oe`, `irq` and `bus_ack` are low.
- R2: Pin n (pad vector index n) maps to bit 31-n of every register. A direction bit of 1 makes the pin drive, so `pad_oe[n]` is 1 and `pad_out[n]` follows data bit 31-n. A direction bit of 0 keeps `pad_oe[n]` at 0.
- R3: For a driving pin whose open-drain bit is 1, a data bit of 0 drives the pad low (`pad_oe`=1, `pad_out`=0). A data bit of 1 releases the pad (`pad_oe`=0).
- R4: A data register read returns the output latch in bits whose direction is 1. In bits whose direction is 0, it returns the pad level once that level has been held for two clocks.
- R5: A request seen in `BS_IDLE` is acknowledged in the next cycle, and only for that one cycle. A read returns its data with that acknowledge. Register offsets are: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, sense 0x14. Any other offset reads zero, and writes to it change nothing.
- R6: A write to the event register clears each event bit written with a 1 and leaves each bit written with a 0 unchanged. Writing all ones clears every event.
- R7: A sense bit of 1 lets only falling edges set the event bit. A sense bit of 0 lets both rising and falling edges set it.
- R8: `irq` is high exactly when some bit is set in both the event and mask registers. A mask of zero keeps `irq` low.
- R9: Events are captured even while their mask bit is 0. Setting the mask bit afterwards raises `irq`.
- R10: If an edge sets an event in the same cycle that a write clears it, the event stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| pad_in | input | 32 | Pad levels, index = pin number |
| pad_out | output | 32 | Pad drive values, index = pin number |
| pad_oe | output | 32 | Pad output enables, index = pin number |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can land on the same register bit in one clock: an edge that sets an event, and a write-one-to-clear of that same event. The bench starts with the bit already pending. It changes a pad just after a falling clock edge and waits two rising edges, so that the edge is detected in the cycle that follows. It issues the clearing write so that the write is accepted on exactly that rising edge. A read of the event register afterwards must show the bit still set, and an assertion checks that every detected edge is present in the event register on the next cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam logic [7:0] OFF_DIR  = 8'h00;
    localparam logic [7:0] OFF_ODE  = 8'h04;
    localparam logic [7:0] OFF_DAT  = 8'h08;
    localparam logic [7:0] OFF_EVT  = 8'h0C;
    localparam logic [7:0] OFF_MSK  = 8'h10;
    localparam logic [7:0] OFF_SNS  = 8'h14;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_RESP = 1'b1
    } bus_state_t;
endpackage

// File: rtl/pio_bus_fsm.sv
module pio_bus_fsm
    import pio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic wr,
    output logic wr_fire,
    output logic rd_fire,
    output logic ack
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    // transitions: accept (IDLE->RESP), release (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: if (req) state_d = BS_RESP;
            BS_RESP: state_d = BS_IDLE;
        endcase
    end

    always_comb begin
        wr_fire = 1'b0;
        rd_fire = 1'b0;
        ack     = 1'b0;
        unique case (state_q)
            BS_IDLE: begin
                wr_fire = req & wr;
                rd_fire = req & ~wr;
            end
            BS_RESP: ack = 1'b1;
        endcase
    end
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pio_edge.sv
module pio_edge #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] fall_only,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
    assign hit  = fall | (rise & ~fall_only);
endmodule

// File: rtl/pio32_ctrl.sv
module pio32_ctrl
    import pio_pkg::*;
#(
    parameter int PIN_W  = 32,
    parameter int ADDR_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic              bus_ack,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic              irq
);
    localparam int TOP = PIN_W - 1;

    logic [PIN_W-1:0] dir_q, ode_q, dat_q, evt_q, msk_q, sns_q;
    logic [PIN_W-1:0] pin_raw, pin_lvl, hit, evt_w1c, rd_mux, rdata_q;
    logic [PIN_W-1:0] oe_reg;
    logic             wr_fire, rd_fire;

    pio_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(bus_wr),
        .wr_fire(wr_fire), .rd_fire(rd_fire), .ack(bus_ack)
    );

    // pin n <-> register bit TOP-n
    for (genvar n = 0; n < PIN_W; n++) begin : g_map
        assign pin_raw[TOP-n] = pad_in[n];
        assign pad_out[n]     = dat_q[TOP-n];
        assign pad_oe[n]      = oe_reg[TOP-n];
    end

    pio_sync #(.W(PIN_W), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_lvl)
    );

    pio_edge #(.W(PIN_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(pin_lvl), .fall_only(sns_q), .hit(hit)
    );

    assign oe_reg  = dir_q & (~ode_q | ~dat_q);
    assign evt_w1c = (wr_fire && bus_addr == ADDR_W'(OFF_EVT)) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            ode_q <= '0;
            dat_q <= '0;
            msk_q <= '0;
            sns_q <= '0;
        end else if (wr_fire) begin
            if (bus_addr == ADDR_W'(OFF_DIR)) dir_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_ODE)) ode_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_DAT)) dat_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_MSK)) msk_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFF_SNS)) sns_q <= bus_wdata;
        end
    end

    // set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~evt_w1c) | hit;
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(OFF_DIR)) rd_mux = dir_q;
        if (bus_addr == ADDR_W'(OFF_ODE)) rd_mux = ode_q;
        if (bus_addr == ADDR_W'(OFF_DAT)) rd_mux = (dat_q & dir_q) | (pin_lvl & ~dir_q);
        if (bus_addr == ADDR_W'(OFF_EVT)) rd_mux = evt_q;
        if (bus_addr == ADDR_W'(OFF_MSK)) rd_mux = msk_q;
        if (bus_addr == ADDR_W'(OFF_SNS)) rd_mux = sns_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign irq       = |(evt_q & msk_q);
endmodule

// File: rtl/pio32_ctrl_chk.sv
module pio32_ctrl_chk #(
    parameter int PIN_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_ack,
    input logic             irq,
    input logic [PIN_W-1:0] pad_oe,
    input logic [PIN_W-1:0] dir_q,
    input logic [PIN_W-1:0] msk_q,
    input logic [PIN_W-1:0] evt_q,
    input logic [PIN_W-1:0] evt_w1c,
    input logic [PIN_W-1:0] hit
);
    logic [PIN_W-1:0] dir_pin;
    for (genvar n = 0; n < PIN_W; n++) begin : g_rev
        assign dir_pin[n] = dir_q[PIN_W-1-n];
    end

    a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    a_r2_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_pin) == '0);

    a_r8_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_q == '0) |-> !irq);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_q) & ~evt_q & ~$past(evt_w1c)) == '0);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((evt_q & $past(hit)) == $past(hit)));
endmodule

bind pio32_ctrl pio32_ctrl_chk #(.PIN_W(PIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_ack(bus_ack), .irq(irq), .pad_oe(pad_oe),
    .dir_q(dir_q), .msk_q(msk_q), .evt_q(evt_q), .evt_w1c(evt_w1c), .hit(hit)
);

// File: tb/tb_pio32_ctrl.sv
module tb_pio32_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, pad_in = '0;
    logic        bus_ack, irq;
    logic [31:0] bus_rdata, pad_out, pad_oe;

    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pio32_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq)
    );

    // {dir, open-drain, data, pad levels in register bit order}
    localparam logic [127:0] VEC [4] = '{
        {32'hFFFF0000, 32'h00000000, 32'hA5A55A5A, 32'h0F0F3C3C},
        {32'hFFFFFFFF, 32'hF0F0F0F0, 32'hCCCCCCCC, 32'h00000000},
        {32'h00000000, 32'h00000000, 32'h00000000, 32'h12345678},
        {32'h80000001, 32'h80000000, 32'h80000001, 32'h7FFFFFFE}
    };

    function automatic logic [31:0] rev(input logic [31:0] v);
        for (int i = 0; i < 32; i++) rev[i] = v[31-i];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at a negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_req = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_req = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        chk("R5 ack", {31'b0, bus_ack}, 32'd1);
        d = bus_rdata;
        bus_req = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, e;
        repeat (3) @(negedge clk);
        chk("R1 oe", pad_oe, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 ack", {31'b0, bus_ack}, 32'h0);
        rst_n = 1;
        @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            rd(8'(a * 4), v);
            chk("R1 reg zero", v, 32'h0);
        end

        // R5: unmapped offsets
        wr(8'h1C, 32'hFFFFFFFF);
        rd(8'h1C, v); chk("R5 unmapped read", v, 32'h0);
        rd(8'h00, v); chk("R5 unmapped write ignored", v, 32'h0);
        chk("R5 unmapped write no oe", pad_oe, 32'h0);

        // vector table: R2 R3 R4
        for (int i = 0; i < 4; i++) begin
            logic [31:0] vd, vo, vt, vp;
            {vd, vo, vt, vp} = VEC[i];
            pad_in = rev(vp);
            wr(8'h00, vd);
            wr(8'h04, vo);
            wr(8'h08, vt);
            @(negedge clk);
            chk("R2/R3 pad_oe", pad_oe, rev(vd & (~vo | ~vt)));
            chk("R2 pad_out", pad_out, rev(vt));
            rd(8'h08, v);
            chk("R4 data read", v, (vt & vd) | (vp & ~vd));
        end

        // back to inputs, quiet pads, clear all events
        wr(8'h00, 32'h0);
        pad_in = 32'h0;
        repeat (4) @(negedge clk);
        wr(8'h0C, 32'hFFFFFFFF);
        rd(8'h0C, v); chk("R6 clear all", v, 32'h0);

        // R7 both edges on pin 3 (bit 28)
        pad_in[3] = 1; repeat (4) @(negedge clk);
        rd(8'h0C, v); chk("R7 rising with sense 0", v, 32'h10000000);
        wr(8'h0C, 32'h0);
        rd(8'h0C, v); chk("R6 write zero keeps", v, 32'h10000000);
        wr(8'h0C, 32'h10000000);
        rd(8'h0C, v); chk("R6 write one clears", v, 32'h0);
        pad_in[3] = 0; repeat (4) @(negedge clk);
        rd(8'h0C, v); chk("R7 falling with sense 0", v, 32'h10000000);
        wr(8'h0C, 32'hFFFFFFFF);

        // R7 falling only on pin 5 (bit 26)
        wr(8'h14, 32'h04000000);
        pad_in[5] = 1; repeat (4) @(negedge clk);
        rd(8'h0C, v); chk("R7 rising ignored with sense 1", v, 32'h0);
        chk("R8 no irq", {31'b0, irq}, 32'h0);
        pad_in[5] = 0; repeat (4) @(negedge clk);
        rd(8'h0C, v); chk("R9 event captured while masked", v, 32'h04000000);
        chk("R8 masked irq low", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'h04000000);
        chk("R9 unmask raises irq", {31'b0, irq}, 32'h1);
        wr(8'h10, 32'h0);
        chk("R8 zero mask drops irq", {31'b0, irq}, 32'h0);
        wr(8'h10, 32'h04000000);
        wr(8'h0C, 32'h04000000);
        chk("R8 irq low after clear", {31'b0, irq}, 32'h0);

        // R10: edge detected in the same cycle as clearing write
        pad_in[3] = 1; repeat (4) @(negedge clk);
        pad_in[3] = 0;
        @(negedge clk); @(negedge clk);
        wr(8'h0C, 32'h10000000);
        rd(8'h0C, v); e = 32'h10000000;
        chk("R10 set wins over clear", v, e);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule